// File: doc/BRIEF.md
# Multi-Cycle Arithmetic Shift Unit

This unit performs arithmetic shifts of one 16-bit word or of a 32-bit pair of words and reports the condition flags N, Z, V and C. The shift field is a signed 6-bit two's-complement value. A positive value moves bits toward the most significant end. A negative value moves them toward the least significant end by its magnitude. The unit processes one bit position per clock. Any number of steps can therefore run through the same small datapath.

A requester presents the mode, the operand words, the shift field and an odd-register indication, then pulses `start` for one cycle while the unit is idle. Some cycles later `done` pulses for one cycle. At that point the unit presents two words: the word to write to the named register, and a second word together with an enable for the partner register. Reading operands from a register file and writing results back to it happen outside this block.

Top module: `arith_shift_unit`

## Requirements
- R1: `shift_field` is read as a signed 6-bit count. Bit 5 clear means a left shift by the field value (0 to 31). Bit 5 set means a right shift by the magnitude of the negative value (1 to 32).
- R2: A right step copies the sign bit into the top position. In combined mode `word_hi` is the upper half and `word_lo` the lower half of the value, and the bit leaving the bottom of the high word enters the top of the low word.
- R3: A left step puts zero into bit 0. In combined mode the bit leaving the top of the low word enters bit 0 of the high word.
- R4: `flag_c` equals the bit removed by the final step. A count of zero gives `flag_c` = 0.
- R5: `flag_v` is 1 when the sign bit changed on at least one left step of the operation. Once set it stays set. It is 0 for right shifts and for a zero count.
- R6: A count of zero returns the operand unchanged.
- R7: In single mode only `word_hi` is shifted and `word_lo` is ignored. `flag_n` is bit 15 of the result and `flag_z` is 1 when the 16-bit result is zero.
- R8: In combined mode `flag_n` is bit 15 of the high result word. `flag_z` is 1 only when both result words are zero.
- R9: Write-back selection works as follows.
  - Single mode: `res_main` is the result and `pair_wr` is 0.
  - Combined mode with `odd_reg` = 0: `res_main` is the high word, `res_pair` is the low word, and `pair_wr` is 1.
  - Combined mode with `odd_reg` = 1: `res_main` is the low word and `pair_wr` is 0.
- R10: `done` is high for exactly one cycle, on the clock edge that is magnitude+1 edges after the edge that accepted `start`. Outputs keep their values until the next `done`.
- R11: A `start` pulse that arrives while an operation is in progress is ignored.
- R12: While reset is active and after it is released, `done` is 0 and all result and flag outputs are 0 until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| combined | input | 1 | 1 = 32-bit pair shift, 0 = single word |
| odd_reg | input | 1 | Named register index is odd |
| shift_field | input | 6 | Signed shift count |
| word_hi | input | 16 | Single operand, or high half of the pair |
| word_lo | input | 16 | Low half of the pair |
| res_main | output | 16 | Word for the named register |
| res_pair | output | 16 | Word for the partner register |
| pair_wr | output | 1 | Partner register write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Sign-change flag |
| flag_c | output | 1 | Last bit shifted out |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets several corner cases of the unit.
- A double left step that flips the sign and then flips it back. A V flag that is not sticky ends up clear here.
- A 32-place right shift of a negative pair, which must produce all ones with C set.
- A 31-place left shift that pushes every bit out.
- A zero count, where stale C or V values would leak through.
- Odd-register pair operations, where writing the high word or asserting the partner enable would corrupt a neighbouring register.
- A combined shift whose high word is zero but whose low word is not, which catches a Z flag taken from only one half.
- A start pulse issued in the middle of an operation, which would restart or corrupt the unit if it were not ignored. Latency is counted for every vector, which exposes off-by-one step counts.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } asu_flags_t;

endpackage

// File: rtl/asu_rst_sync.sv
module asu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/asu_count_decode.sv
module asu_count_decode #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] field,
  output logic             go_left,
  output logic [CNT_W-1:0] magnitude
);
  always_comb begin
    go_left   = ~field[CNT_W-1];
    magnitude = go_left ? field : (~field + 1'b1);
  end
endmodule

// File: rtl/asu_step.sv
module asu_step #(
  parameter int W = 16
) (
  input  logic         pair_mode,
  input  logic         go_left,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic         bit_out,
  output logic         sign_flip
);
  always_comb begin
    hi_out    = hi_in;
    lo_out    = lo_in;
    bit_out   = 1'b0;
    sign_flip = 1'b0;
    if (go_left) begin
      bit_out   = hi_in[W-1];
      sign_flip = hi_in[W-1] ^ hi_in[W-2];
      if (pair_mode) begin
        hi_out = {hi_in[W-2:0], lo_in[W-1]};
        lo_out = {lo_in[W-2:0], 1'b0};
      end else begin
        hi_out = {hi_in[W-2:0], 1'b0};
      end
    end else begin
      hi_out = {hi_in[W-1], hi_in[W-1:1]};
      if (pair_mode) begin
        lo_out  = {hi_in[0], lo_in[W-1:1]};
        bit_out = lo_in[0];
      end else begin
        bit_out = hi_in[0];
      end
    end
  end
endmodule

// File: rtl/asu_writeback.sv
module asu_writeback #(
  parameter int W = 16
) (
  input  logic         pair_mode,
  input  logic         odd_idx,
  input  logic [W-1:0] hi_val,
  input  logic [W-1:0] lo_val,
  output logic [W-1:0] main_word,
  output logic [W-1:0] pair_word,
  output logic         pair_en,
  output logic         neg,
  output logic         zero
);
  always_comb begin
    neg       = hi_val[W-1];
    zero      = pair_mode ? ((hi_val == '0) && (lo_val == '0)) : (hi_val == '0);
    main_word = (pair_mode && odd_idx) ? lo_val : hi_val;
    pair_word = lo_val;
    pair_en   = pair_mode & ~odd_idx;
  end
endmodule

// File: rtl/arith_shift_unit.sv
module arith_shift_unit #(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             combined,
  input  logic             odd_reg,
  input  logic [CNT_W-1:0] shift_field,
  input  logic [W-1:0]     word_hi,
  input  logic [W-1:0]     word_lo,
  output logic [W-1:0]     res_main,
  output logic [W-1:0]     res_pair,
  output logic             pair_wr,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             done
);
  import asu_pkg::*;

  logic srst_n;

  asu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Operation state
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     hi_q, hi_d, lo_q, lo_d;
  logic             comb_q, comb_d, odd_q, odd_d, left_q, left_d;
  logic             c_q, c_d, v_q, v_d;
  logic             done_q, done_d;

  // Result holding registers
  logic             out_en;
  logic [W-1:0]     main_q, main_d, pair_q, pair_d;
  logic             pwr_q, pwr_d;
  asu_flags_t       flg_q, flg_d;

  // Decoded count
  logic             dec_left;
  logic [CNT_W-1:0] dec_mag;

  asu_count_decode #(.CNT_W(CNT_W)) u_dec (
    .field     (shift_field),
    .go_left   (dec_left),
    .magnitude (dec_mag)
  );

  // One-bit shift step
  logic [W-1:0] st_hi, st_lo;
  logic         st_out, st_flip;

  asu_step #(.W(W)) u_step (
    .pair_mode (comb_q),
    .go_left   (left_q),
    .hi_in     (hi_q),
    .lo_in     (lo_q),
    .hi_out    (st_hi),
    .lo_out    (st_lo),
    .bit_out   (st_out),
    .sign_flip (st_flip)
  );

  // Write-back selection and N/Z
  logic [W-1:0] wb_main, wb_pair;
  logic         wb_en, wb_n, wb_z;

  asu_writeback #(.W(W)) u_wb (
    .pair_mode (comb_q),
    .odd_idx   (odd_q),
    .hi_val    (hi_q),
    .lo_val    (lo_q),
    .main_word (wb_main),
    .pair_word (wb_pair),
    .pair_en   (wb_en),
    .neg       (wb_n),
    .zero      (wb_z)
  );

  logic accept, stepping, finishing;

  always_comb begin
    accept    = ~busy_q & start;
    stepping  = busy_q & (cnt_q != '0);
    finishing = busy_q & (cnt_q == '0);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    comb_d = comb_q;
    odd_d  = odd_q;
    left_d = left_q;
    c_d    = c_q;
    v_d    = v_q;
    done_d = 1'b0;

    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = dec_mag;
      hi_d   = word_hi;
      lo_d   = combined ? word_lo : '0;
      comb_d = combined;
      odd_d  = odd_reg;
      left_d = dec_left;
      c_d    = 1'b0;
      v_d    = 1'b0;
    end else if (stepping) begin
      cnt_d = cnt_q - 1'b1;
      hi_d  = st_hi;
      lo_d  = st_lo;
      c_d   = st_out;
      v_d   = v_q | st_flip;
    end else if (finishing) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end

    out_en = finishing;
    main_d = wb_main;
    pair_d = wb_pair;
    pwr_d  = wb_en;
    flg_d  = '{n: wb_n, z: wb_z, v: v_q, c: c_q};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      comb_q <= 1'b0;
      odd_q  <= 1'b0;
      left_q <= 1'b0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      comb_q <= comb_d;
      odd_q  <= odd_d;
      left_q <= left_d;
      c_q    <= c_d;
      v_q    <= v_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      main_q <= '0;
      pair_q <= '0;
      pwr_q  <= 1'b0;
      flg_q  <= '0;
    end else if (out_en) begin
      main_q <= main_d;
      pair_q <= pair_d;
      pwr_q  <= pwr_d;
      flg_q  <= flg_d;
    end
  end

  assign res_main = main_q;
  assign res_pair = pair_q;
  assign pair_wr  = pwr_q;
  assign flag_n   = flg_q.n;
  assign flag_z   = flg_q.z;
  assign flag_v   = flg_q.v;
  assign flag_c   = flg_q.c;
  assign done     = done_q;

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    done_q |=> !done_q);

  // R10: the step counter falls by exactly one per shifting cycle
  a_r10_count_down: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5: once a sign change is seen, V stays set for the operation
  a_r5_v_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_q && v_q) |=> v_q);

  // R4, R5: a zero count finishes after one edge with C and V clear
  a_r4_zero_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_q && start && dec_mag == '0) |=> ##1 (done_q && !flag_c && !flag_v));

  // R11: mode and direction cannot change mid-operation
  a_r11_ignore_start: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_q && cnt_q != '0) |=> ($stable(comb_q) && $stable(left_q) && busy_q));

endmodule

// File: tb/arith_shift_unit_test.sv
module arith_shift_unit_test;
  localparam int W = 16;
  localparam int N_VEC = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, combined, odd_reg;
  logic [5:0]    shift_field;
  logic [W-1:0]  word_hi, word_lo;
  logic [W-1:0]  res_main, res_pair;
  logic          pair_wr, flag_n, flag_z, flag_v, flag_c, done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  arith_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .combined(combined),
    .odd_reg(odd_reg), .shift_field(shift_field), .word_hi(word_hi),
    .word_lo(word_lo), .res_main(res_main), .res_pair(res_pair),
    .pair_wr(pair_wr), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .done(done)
  );

  // {comb, odd, field, hi, lo, exp_main, exp_pair, exp_pwr, exp_nzvc}
  localparam logic [76:0] VEC [N_VEC] = '{
    {1'b0, 1'b0, 6'h03, 16'h0001, 16'hFFFF, 16'h0008, 16'h0000, 1'b0, 4'b0000},
    {1'b0, 1'b0, 6'h3F, 16'h8001, 16'h0000, 16'hC000, 16'h0000, 1'b0, 4'b1001},
    {1'b0, 1'b0, 6'h01, 16'h4000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 4'b1010},
    {1'b0, 1'b0, 6'h02, 16'h4000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0111},
    {1'b0, 1'b0, 6'h00, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 4'b1000},
    {1'b1, 1'b0, 6'h04, 16'h0000, 16'h1234, 16'h0001, 16'h2340, 1'b1, 4'b0000},
    {1'b1, 1'b0, 6'h3C, 16'h8000, 16'h0008, 16'hF800, 16'h0000, 1'b1, 4'b1001},
    {1'b1, 1'b1, 6'h08, 16'h0000, 16'h00FF, 16'hFF00, 16'hFF00, 1'b0, 4'b0000},
    {1'b1, 1'b0, 6'h20, 16'h8000, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b1, 4'b1001},
    {1'b0, 1'b0, 6'h1F, 16'h0001, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 4'b0110},
    {1'b0, 1'b0, 6'h30, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0100},
    {1'b1, 1'b0, 6'h01, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000, 1'b1, 4'b1010},
    {1'b1, 1'b0, 6'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'b0100},
    {1'b1, 1'b0, 6'h3F, 16'h0000, 16'h0002, 16'h0000, 16'h0001, 1'b1, 4'b0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pulses start, returns negedges until done (0 if it never came).
  task automatic run_op(input logic c, input logic o, input logic [5:0] f,
                        input logic [W-1:0] h, input logic [W-1:0] l,
                        output int lat);
    combined = c; odd_reg = o; shift_field = f; word_hi = h; word_lo = l;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 1; k <= 80; k++) begin
      if (done) begin
        lat = k;
        break;
      end
      @(negedge clk);
    end
  endtask

  function automatic int mag_of(input logic [5:0] f);
    return f[5] ? (64 - int'(f)) : int'(f);
  endfunction

  initial begin
    int lat;
    int pulses;
    logic [W-1:0] held;
    start = 0; combined = 0; odd_reg = 0; shift_field = 0;
    word_hi = 0; word_lo = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: outputs during reset
    chk("R12 done in reset", done, 0);
    chk("R12 result in reset", {res_main, res_pair}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 flags after reset", {pair_wr, flag_n, flag_z, flag_v, flag_c, done}, 0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [76:0] v;
      v = VEC[i];
      run_op(v[76], v[75], v[74:69], v[68:53], v[52:37], lat);
      chk($sformatf("R1 R10 latency vec%0d", i), lat, mag_of(v[74:69]) + 2);
      chk($sformatf("R2 R3 R6 main vec%0d", i), res_main, v[36:21]);
      chk($sformatf("R9 pair enable vec%0d", i), pair_wr, v[4]);
      if (v[4]) chk($sformatf("R2 R3 R9 pair word vec%0d", i), res_pair, v[20:5]);
      chk($sformatf("R4 R5 R7 R8 flags NZVC vec%0d", i),
          {flag_n, flag_z, flag_v, flag_c}, v[3:0]);
      @(negedge clk);
      chk($sformatf("R10 done one cycle vec%0d", i), done, 0);
    end

    // R11: second start during an operation is ignored
    combined = 0; odd_reg = 0; shift_field = 6'h0A; word_hi = 16'h0001; word_lo = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    shift_field = 6'h3F; word_hi = 16'hFFFF; combined = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pulses = 0;
    lat = 0;
    for (int k = 5; k <= 40; k++) begin
      if (done) begin
        pulses++;
        if (lat == 0) lat = k;
        held = res_main;
        chk("R11 first op result kept", res_main, 16'h0400);
        chk("R11 first op mode kept", pair_wr, 0);
      end
      @(negedge clk);
    end
    chk("R11 single done pulse", pulses, 1);
    chk("R11 R10 latency unaffected", lat, 12);

    // R10: outputs hold while idle and inputs change
    word_hi = 16'h5555; shift_field = 6'h05;
    repeat (5) @(negedge clk);
    chk("R10 result held", res_main, 16'h0400);
    chk("R10 flags held", {flag_n, flag_z, flag_v, flag_c}, 4'b0000);

    // R12: reset mid-operation clears outputs
    run_op(1'b0, 1'b0, 6'h01, 16'h4000, 16'h0000, lat);
    chk("R5 setup before reset", flag_v, 1);
    combined = 0; shift_field = 6'h1F; word_hi = 16'h0001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset clears", {res_main, flag_v, flag_n, done}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R12 no done after reset", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule